// File: doc/BRIEF.md
# Mixed-Width True Dual-Port Block Memory

This block is a scaled-down on-chip memory with two ports, A and B. Each port has its own clock, enable, write enable, address, write data and registered read data. The ports share only the stored contents. Each port has its own read shape and write shape, and the two can differ. A shape is taken from the set 1, 2, 4, 9, 18 and 36 bits, and every shape spans the same storage. The array holds `DATA_BITS` data bits (512 by default). It also holds a side array of `DATA_BITS/8` parity bits, which only the 9-, 18- and 36-bit shapes can reach.

Writes land on the clock edge of the writing port. Reads are captured into a per-port output register on that port's edge. A read returns the contents as they were before any write on that same edge. A reset loads the whole array, data and parity, from two parameters and clears both read registers. The block can serve as one wide buffer that is filled through one shape and drained through another, for example a 9-bit byte-with-parity feed read back as 36-bit words.

Top module: `mwdp_ram`

## Requirements
- R1: A synchronous reset (`rst` high at an edge of each port clock) reloads every data bit from `INIT_DATA` and every parity bit from `INIT_PAR`, and sets both read registers to zero.
- R2: With `en` high at an edge, `rdata` holds the addressed word after that edge. With `en` low, `rdata` keeps its value.
- R3: A shape of width W carries D data bits, where D = W for the 1, 2 and 4 shapes and D = 8W/9 for the 9, 18 and 36 shapes. It addresses unit idx = addr mod (DATA_BITS/D) and covers data bits idx*D to idx*D+D-1. Lower port lanes map to lower data bits.
- R4: In the 9, 18 and 36 shapes, port bits 9k to 9k+7 are data lane k and port bit 9k+8 is its parity bit, stored at parity index idx*(W/9)+k. The 1, 2 and 4 shapes neither read nor change parity.
- R5: When a port writes and reads on the same edge, its read register shows the contents from before that write (read-first).
- R6: Data written through one port is read back through the other port at that port's own shape, from the edge after the write.
- R7: A port with `en` low, or with `we` low, changes no stored bit.
- R8: Read-data bits at or above the port's read width are zero. Address bits above the unit index are ignored.
- R9: Both ports may write disjoint bits on the same edge, and both writes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, seen by both port clocks |
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write enable (acts only with en_a) |
| addr_a | input | ADDR_W | Port A unit address |
| wdata_a | input | 36 | Port A write data, low WR_W_A bits used |
| rdata_a | output | 36 | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write enable (acts only with en_b) |
| addr_b | input | ADDR_W | Port B unit address |
| wdata_b | input | 36 | Port B write data, low WR_W_B bits used |
| rdata_b | output | 36 | Port B registered read data |

## Verification
Two things can fall on the same edge: a write from each port, and a port's write together with its own read. The bench provokes the first by having port A write a 9-bit lane and port B write a 2-bit pair on one edge, in regions that do not overlap. It provokes the second with rows in which a port reads the address it is writing. For the concurrent writes, a later read through each port shape must show both updates. For the same-port case, the read taken on the writing edge must show the old contents. Rows in which one port reads bits that the other port writes on the same edge are kept out of the stimulus, because that outcome is undefined.

// File: rtl/mwdp_pkg.sv
`timescale 1ns/1ps
package mwdp_pkg;
  localparam int PORT_W = 36;
  localparam int LANE_W = 9;

  // data bits carried by a shape of width w
  function automatic int data_bits(input int w);
    return (w % LANE_W == 0) ? (w / LANE_W) * 8 : w;
  endfunction

  // parity bits carried by a shape of width w
  function automatic int par_bits(input int w);
    return (w % LANE_W == 0) ? w / LANE_W : 0;
  endfunction

  // port bit that carries data bit d of a shape
  function automatic int data_to_port(input int w, input int d);
    return (par_bits(w) > 0) ? (d / 8) * LANE_W + (d % 8) : d;
  endfunction

  // data bit carried by (non-parity) port bit k of a shape
  function automatic int port_to_data(input int w, input int k);
    return (par_bits(w) > 0) ? (k / LANE_W) * 8 + (k % LANE_W) : k;
  endfunction
endpackage

// File: rtl/mwdp_wr_map.sv
`timescale 1ns/1ps
module mwdp_wr_map
  import mwdp_pkg::*;
#(
  parameter int DATA_BITS = 512,
  parameter int WR_W      = 9,
  parameter int ADDR_W    = $clog2(DATA_BITS)
) (
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [PORT_W-1:0]      wdata,
  output logic [DATA_BITS-1:0]   d_mask,
  output logic [DATA_BITS-1:0]   d_val,
  output logic [DATA_BITS/8-1:0] p_mask,
  output logic [DATA_BITS/8-1:0] p_val
);
  localparam int DB     = data_bits(WR_W);
  localparam int PB     = par_bits(WR_W);
  localparam int DEPTH  = DATA_BITS / DB;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int BIT_W  = $clog2(DATA_BITS);
  localparam int PAR_N  = DATA_BITS / 8;
  localparam int PBIT_W = $clog2(PAR_N);

  logic [IDX_W-1:0] idx;
  logic [BIT_W-1:0] d_off;
  logic [DB-1:0]    lane_d;
  logic             unused_wr;

  assign idx   = IDX_W'(addr);
  assign d_off = BIT_W'(idx) << $clog2(DB);

  // gather data bits out of the lane-with-parity port layout
  for (genvar d = 0; d < DB; d++) begin : g_dsel
    localparam int SRC = data_to_port(WR_W, d);
    assign lane_d[d] = wdata[SRC];
  end

  assign d_mask = {{(DATA_BITS-DB){1'b0}}, {DB{we}}} << d_off;
  assign d_val  = {{(DATA_BITS-DB){1'b0}}, lane_d} << d_off;

  if (PB > 0) begin : g_par
    logic [PB-1:0]     lane_p;
    logic [PBIT_W-1:0] p_off;
    for (genvar p = 0; p < PB; p++) begin : g_psel
      assign lane_p[p] = wdata[LANE_W*p + 8];
    end
    assign p_off  = PBIT_W'(idx) << $clog2(PB);
    assign p_mask = {{(PAR_N-PB){1'b0}}, {PB{we}}} << p_off;
    assign p_val  = {{(PAR_N-PB){1'b0}}, lane_p} << p_off;
  end else begin : g_nopar
    assign p_mask = '0;
    assign p_val  = '0;
  end

  assign unused_wr = ^{addr, wdata};
endmodule

// File: rtl/mwdp_rd_map.sv
`timescale 1ns/1ps
module mwdp_rd_map
  import mwdp_pkg::*;
#(
  parameter int DATA_BITS = 512,
  parameter int RD_W      = 36,
  parameter int ADDR_W    = $clog2(DATA_BITS)
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_BITS-1:0]   d_store,
  input  logic [DATA_BITS/8-1:0] p_store,
  output logic [PORT_W-1:0]      word
);
  localparam int DB     = data_bits(RD_W);
  localparam int PB     = par_bits(RD_W);
  localparam int DEPTH  = DATA_BITS / DB;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int BIT_W  = $clog2(DATA_BITS);
  localparam int PBIT_W = $clog2(DATA_BITS / 8);
  localparam int PSL_W  = (PB > 0) ? PB : 1;

  logic [IDX_W-1:0] idx;
  logic [BIT_W-1:0] d_off;
  logic [DB-1:0]    sl_d;
  logic [PSL_W-1:0] sl_p;
  logic             unused_rd;

  assign idx   = IDX_W'(addr);
  assign d_off = BIT_W'(idx) << $clog2(DB);
  assign sl_d  = DB'(d_store >> d_off);

  if (PB > 0) begin : g_par
    logic [PBIT_W-1:0] p_off;
    assign p_off = PBIT_W'(idx) << $clog2(PB);
    assign sl_p  = PSL_W'(p_store >> p_off);
  end else begin : g_nopar
    assign sl_p = '0;
  end

  // place data lanes and parity bits into the port layout, pad with zero
  for (genvar k = 0; k < PORT_W; k++) begin : g_bit
    if (k >= RD_W) begin : g_pad
      assign word[k] = 1'b0;
    end else if (PB > 0 && (k % LANE_W) == 8) begin : g_p
      assign word[k] = sl_p[k / LANE_W];
    end else begin : g_d
      localparam int SRC = port_to_data(RD_W, k);
      assign word[k] = sl_d[SRC];
    end
  end

  assign unused_rd = ^{addr, sl_p, p_store};
endmodule

// File: rtl/mwdp_bank.sv
`timescale 1ns/1ps
module mwdp_bank #(
  parameter int               CELLS   = 576,
  parameter bit               OWNER_B = 1'b0,
  parameter logic [CELLS-1:0] INIT    = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CELLS-1:0] wr_mask,
  input  logic [CELLS-1:0] wr_val,
  input  logic [CELLS-1:0] tag_other,
  output logic [CELLS-1:0] store,
  output logic [CELLS-1:0] tag
);
  // tag rule: A copies B's tag (xor -> 0), B inverts A's tag (xor -> 1)
  logic [CELLS-1:0] claim;
  assign claim = OWNER_B ? ~tag_other : tag_other;

  always_ff @(posedge clk) begin
    if (rst) begin
      store <= INIT;
      tag   <= '0;
    end else begin
      store <= (store & ~wr_mask) | (wr_val & wr_mask);
      tag   <= (tag & ~wr_mask) | (claim & wr_mask);
    end
  end

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_mask == '0) |=> $stable(store));

  // R1
  bank_init_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (store == INIT));

  // R6
  bank_own_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_mask != '0) |=> (((tag ^ tag_other) & $past(wr_mask)) ==
                          (OWNER_B ? $past(wr_mask) : '0)));
endmodule

// File: rtl/mwdp_ram.sv
`timescale 1ns/1ps
module mwdp_ram
  import mwdp_pkg::*;
#(
  parameter int DATA_BITS = 512,
  parameter int WR_W_A    = 9,
  parameter int RD_W_A    = 36,
  parameter int WR_W_B    = 2,
  parameter int RD_W_B    = 18,
  parameter int ADDR_W    = $clog2(DATA_BITS),
  parameter logic [DATA_BITS-1:0]   INIT_DATA = '0,
  parameter logic [DATA_BITS/8-1:0] INIT_PAR  = '0
) (
  input  logic              rst,
  input  logic              clk_a,
  input  logic              en_a,
  input  logic              we_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [PORT_W-1:0] wdata_a,
  output logic [PORT_W-1:0] rdata_a,
  input  logic              clk_b,
  input  logic              en_b,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [PORT_W-1:0] wdata_b,
  output logic [PORT_W-1:0] rdata_b
);
  localparam int PAR_N = DATA_BITS / 8;
  localparam int CELLS = DATA_BITS + PAR_N;
  localparam logic [CELLS-1:0] INIT_ALL = {INIT_PAR, INIT_DATA};

  logic [DATA_BITS-1:0] dm_a, dv_a, dm_b, dv_b;
  logic [PAR_N-1:0]     pm_a, pv_a, pm_b, pv_b;
  logic [CELLS-1:0]     store_a, store_b, tag_a, tag_b, live, merged;
  logic [PORT_W-1:0]    word_a, word_b;

  mwdp_wr_map #(.DATA_BITS(DATA_BITS), .WR_W(WR_W_A), .ADDR_W(ADDR_W)) u_wr_a (
    .we(en_a & we_a), .addr(addr_a), .wdata(wdata_a),
    .d_mask(dm_a), .d_val(dv_a), .p_mask(pm_a), .p_val(pv_a));

  mwdp_wr_map #(.DATA_BITS(DATA_BITS), .WR_W(WR_W_B), .ADDR_W(ADDR_W)) u_wr_b (
    .we(en_b & we_b), .addr(addr_b), .wdata(wdata_b),
    .d_mask(dm_b), .d_val(dv_b), .p_mask(pm_b), .p_val(pv_b));

  mwdp_bank #(.CELLS(CELLS), .OWNER_B(1'b0), .INIT(INIT_ALL)) u_bank_a (
    .clk(clk_a), .rst(rst), .wr_mask({pm_a, dm_a}), .wr_val({pv_a, dv_a}),
    .tag_other(tag_b), .store(store_a), .tag(tag_a));

  mwdp_bank #(.CELLS(CELLS), .OWNER_B(1'b1), .INIT(INIT_ALL)) u_bank_b (
    .clk(clk_b), .rst(rst), .wr_mask({pm_b, dm_b}), .wr_val({pv_b, dv_b}),
    .tag_other(tag_a), .store(store_b), .tag(tag_b));

  // per-cell choice of the bank that wrote last
  assign live   = tag_a ^ tag_b;
  assign merged = (store_a & ~live) | (store_b & live);

  mwdp_rd_map #(.DATA_BITS(DATA_BITS), .RD_W(RD_W_A), .ADDR_W(ADDR_W)) u_rd_a (
    .addr(addr_a), .d_store(merged[DATA_BITS-1:0]),
    .p_store(merged[CELLS-1:DATA_BITS]), .word(word_a));

  mwdp_rd_map #(.DATA_BITS(DATA_BITS), .RD_W(RD_W_B), .ADDR_W(ADDR_W)) u_rd_b (
    .addr(addr_b), .d_store(merged[DATA_BITS-1:0]),
    .p_store(merged[CELLS-1:DATA_BITS]), .word(word_b));

  // read registers sample the pre-edge view: read-first
  always_ff @(posedge clk_a) begin
    if (rst)       rdata_a <= '0;
    else if (en_a) rdata_a <= word_a;
  end

  always_ff @(posedge clk_b) begin
    if (rst)       rdata_b <= '0;
    else if (en_b) rdata_b <= word_b;
  end

  // R2
  rd_hold_a_chk: assert property (@(posedge clk_a) disable iff (rst)
    !en_a |=> $stable(rdata_a));

  // R2
  rd_hold_b_chk: assert property (@(posedge clk_b) disable iff (rst)
    !en_b |=> $stable(rdata_b));

  // R1
  rd_clear_a_chk: assert property (@(posedge clk_a) disable iff (rst)
    $past(rst) |-> (rdata_a == '0));

  // R1
  rd_clear_b_chk: assert property (@(posedge clk_b) disable iff (rst)
    $past(rst) |-> (rdata_b == '0));
endmodule

// File: tb/tb_mwdp_ram.sv
`timescale 1ns/1ps
module tb_mwdp_ram;
  localparam int NB = 512;
  localparam int NP = NB / 8;
  localparam int WA = 9;
  localparam int RA = 36;
  localparam int WB = 2;
  localparam int RB = 18;
  localparam logic [NB-1:0] IDATA = {16{32'hC3A5_96E1}};
  localparam logic [NP-1:0] IPAR  = {8{8'h69}};

  typedef struct packed {
    logic        ena;
    logic        wea;
    logic [8:0]  adda;
    logic [35:0] da;
    logic        enb;
    logic        web;
    logic [8:0]  addb;
    logic [35:0] db;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 9'd0,  36'h0,   1'b1, 1'b0, 9'd1,     36'h0},
    '{1'b1, 1'b1, 9'd0,  36'h13C, 1'b0, 1'b0, 9'd0,     36'h0},
    '{1'b1, 1'b0, 9'd0,  36'h0,   1'b1, 1'b0, 9'd0,     36'h0},
    '{1'b1, 1'b0, 9'd1,  36'h0,   1'b1, 1'b1, 9'd5,     36'h2},
    '{1'b1, 1'b0, 9'd0,  36'h0,   1'b1, 1'b1, 9'd255,   36'h1},
    '{1'b1, 1'b1, 9'd63, 36'h0AA, 1'b1, 1'b0, 9'd30,    36'h0},
    '{1'b1, 1'b0, 9'd15, 36'h0,   1'b1, 1'b0, 9'd31,    36'h0},
    '{1'b1, 1'b1, 9'd8,  36'h1FF, 1'b1, 1'b1, 9'd40,    36'h3},
    '{1'b1, 1'b0, 9'd2,  36'h0,   1'b1, 1'b0, 9'd4,     36'h0},
    '{1'b0, 1'b1, 9'd2,  36'h0,   1'b0, 1'b1, 9'd32,    36'h0},
    '{1'b1, 1'b0, 9'd2,  36'h0,   1'b1, 1'b0, 9'h1E4,   36'h0},
    '{1'b1, 1'b0, 9'd8,  36'h0,   1'b1, 1'b0, 9'd4,     36'h0},
    '{1'b1, 1'b0, 9'd2,  36'h0,   1'b1, 1'b0, 9'h1E4,   36'h0}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        en_a, we_a, en_b, we_b;
  logic [8:0]  addr_a, addr_b;
  logic [35:0] wdata_a, wdata_b, rdata_a, rdata_b;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [NB-1:0] m_d;
  logic [NP-1:0] m_p;
  logic [35:0] exp_a, exp_b;

  always #2.5 clk = ~clk;

  mwdp_ram #(
    .DATA_BITS(NB), .WR_W_A(WA), .RD_W_A(RA), .WR_W_B(WB), .RD_W_B(RB),
    .INIT_DATA(IDATA), .INIT_PAR(IPAR)
  ) dut (
    .rst(rst),
    .clk_a(clk), .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
    .wdata_a(wdata_a), .rdata_a(rdata_a),
    .clk_b(clk), .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
    .wdata_b(wdata_b), .rdata_b(rdata_b)
  );

  function automatic logic [35:0] m_read(input int w, input logic [8:0] a);
    int db, pb, idx;
    logic [35:0] r;
    db  = (w % 9 == 0) ? (w / 9) * 8 : w;
    pb  = (w % 9 == 0) ? w / 9 : 0;
    idx = int'(a) % (NB / db);
    r   = '0;
    for (int k = 0; k < w; k++) begin
      logic b;
      if (pb > 0 && k % 9 == 8) b = 1'(m_p >> (idx * pb + k / 9));
      else b = 1'(m_d >> (idx * db + ((pb > 0) ? (k / 9) * 8 + k % 9 : k)));
      r = r | (36'(b) << k);
    end
    return r;
  endfunction

  task automatic m_write(input int w, input logic [8:0] a, input logic [35:0] v);
    int db, pb, idx, pos;
    db  = (w % 9 == 0) ? (w / 9) * 8 : w;
    pb  = (w % 9 == 0) ? w / 9 : 0;
    idx = int'(a) % (NB / db);
    for (int k = 0; k < w; k++) begin
      logic b;
      b = 1'(v >> k);
      if (pb > 0 && k % 9 == 8) begin
        pos = idx * pb + k / 9;
        m_p = (m_p & ~(NP'(1) << pos)) | (NP'(b) << pos);
      end else begin
        pos = idx * db + ((pb > 0) ? (k / 9) * 8 + k % 9 : k);
        m_d = (m_d & ~(NB'(1) << pos)) | (NB'(b) << pos);
      end
    end
  endtask

  task automatic check(input string req, input string what,
                       input logic [35:0] act, input logic [35:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic string row_tag(input int i);
    case (i)
      0:       return "R3";
      1, 3, 5: return "R5";
      2, 4:    return "R4";
      6:       return "R6";
      7, 8:    return "R9";
      10:      return "R8";
      default: return "R7";
    endcase
  endfunction

  // called at a negedge; applies one row, checks after one posedge
  task automatic step(input vec_t v, input string req);
    en_a = v.ena; we_a = v.wea; addr_a = v.adda; wdata_a = v.da;
    en_b = v.enb; we_b = v.web; addr_b = v.addb; wdata_b = v.db;
    if (v.ena) exp_a = m_read(RA, v.adda);
    if (v.enb) exp_b = m_read(RB, v.addb);
    if (v.ena && v.wea) m_write(WA, v.adda, v.da);
    if (v.enb && v.web) m_write(WB, v.addb, v.db);
    @(negedge clk);
    check(req, "port A", rdata_a, exp_a);
    check(req, "port B", rdata_b, exp_b);
    en_a = 1'b0; we_a = 1'b0; en_b = 1'b0; we_b = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: got hang expected finish");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    en_a = 1'b0; we_a = 1'b0; addr_a = '0; wdata_a = '0;
    en_b = 1'b0; we_b = 1'b0; addr_b = '0; wdata_b = '0;
    m_d = IDATA; m_p = IPAR;
    exp_a = '0; exp_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: read registers cleared by reset
    check("R1", "port A after reset", rdata_a, 36'h0);
    check("R1", "port B after reset", rdata_b, 36'h0);

    for (int i = 0; i < NV; i++) step(VEC[i], row_tag(i));

    // R2: idle cycles keep both read registers
    @(negedge clk);
    @(negedge clk);
    check("R2", "port A hold", rdata_a, exp_a);
    check("R2", "port B hold", rdata_b, exp_b);

    // R1: reset again restores the initial contents
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_d = IDATA; m_p = IPAR;
    exp_a = '0; exp_b = '0;
    check("R1", "port A cleared", rdata_a, 36'h0);
    check("R1", "port B cleared", rdata_b, 36'h0);
    step('{1'b1, 1'b0, 9'd0, 36'h0, 1'b1, 1'b0, 9'd0, 36'h0}, "R1");
    step('{1'b1, 1'b0, 9'd2, 36'h0, 1'b1, 1'b0, 9'd4, 36'h0}, "R1");

    summary();
    $finish;
  end
endmodule